// File: doc/BRIEF.md
# Exception Return Frame Validator

This block sequences the return-from-exception operation over a stack frame in memory. It is given a stack address and a start pulse. It then fetches the saved status word, the two halves of the program counter and the frame format word through a simple word-read port. The read port carries a bus-error input.

The format code in the format word sorts the frame into one of three cases: a short frame, which completes at once; a long frame, which needs further checking; or an undefined code, which ends with a format error.

A long frame is handled in three stages:
- A version check on one internal word. A mismatch gives a format error.
- An accessibility probe of the final frame word. A bus error here gives an ordinary bus error.
- A load of the remaining words in ascending order. A bus error here is a double fault that halts the processor.

The new stack pointer is written out only when every word has arrived without error. A failed return therefore leaves the old frame and pointer untouched. On a successful long return the block reports whether the faulted bus cycle must be rerun. That answer comes from the rerun flag in the special status word: a flag of 1 means software already completed the cycle.

Top module: `xret_frame_ctrl`

## Requirements
- R1: After `start_i`, the first four reads are at SP+0, SP+2, SP+4 and SP+6, in that order. At a successful finish, `sr_o` holds the word read from SP+0, and `pc_o` holds {word at SP+2, word at SP+4}.
- R2: A format code of 0 in bits 15:12 of the word at SP+6 selects a short frame. The sequence then ends after exactly 4 reads with result 0 (ok), `sp_new_o` = SP+8 and `rerun_o` = 0.
- R3: A format code other than 0 or 8 ends the sequence after the fourth read with result 1 (format error).
- R4: A format code of 8 selects a long frame. The fifth read is at SP+26. If bits 13:10 of that word differ from parameter `EXP_VER`, the sequence ends with result 1.
- R5: The sixth read of a long frame is the probe of SP+56. A bus error on the probe, or on any of the first five reads, ends the sequence with result 2 (bus error).
- R6: After the probe, the block reads SP+8 to SP+54 in ascending order, skipping SP+26. This makes 29 reads in total. A bus error on any of these reads ends the sequence with result 3 (halt).
- R7: A successful long frame ends with result 0 and `sp_new_o` = SP+58. `rerun_o` is the inverse of bit 15 of the word at SP+8.
- R8: `sp_we_o` pulses, together with the one-cycle `done_o`, only when the result is 0. No other outcome writes the stack pointer.
- R9: `rd_req_o` stays high with `rd_addr_o` stable until `rd_ack_i` or `rd_berr_i` is seen. When both arrive in the same cycle, the bus error takes precedence.
- R10: `start_i` is ignored while a sequence is running. The base address stays the one captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a return sequence (sampled when idle) |
| sp_i | input | ADDR_W | Stack pointer at the start of the frame |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read byte address (even) |
| rd_data_i | input | 16 | Read data, valid with rd_ack_i |
| rd_ack_i | input | 1 | Read completed normally |
| rd_berr_i | input | 1 | Read terminated with bus error |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| result_o | output | 2 | 0 ok, 1 format error, 2 bus error, 3 halt |
| sp_we_o | output | 1 | Stack pointer commit strobe |
| sp_new_o | output | ADDR_W | Committed stack pointer value |
| sr_o | output | 16 | Restored status word |
| pc_o | output | 32 | Restored program counter |
| rerun_o | output | 1 | Faulted cycle must be rerun by hardware |

## Verification
The bench targets the stage boundaries where the fault class changes:
- A bus error on the format word must still count as a bus error, not a format error.
- A bus error on the probe must give a bus error, while one on the first word after the probe must halt. A design that set its double-fault flag one read early or late would swap these outcomes.
- A design that read body words before the probe, or re-read the version word, would fail the per-read address-order comparison.

The remaining cases are aimed at specific faults:
- Frames that fail must show no commit strobe, to catch an early stack-pointer update.
- A start pulse injected mid-frame, and responses that carry ack and bus error together, expose an unguarded restart and a wrong response priority.

// File: rtl/xret_pkg.sv
package xret_pkg;
  localparam int IDX_W        = 5;
  localparam int HEAD_LAST    = 3;
  localparam int SSW_IDX      = 4;
  localparam int VER_IDX      = 13;
  localparam int PROBE_IDX    = 28;
  localparam int BODY_LAST    = PROBE_IDX - 1;
  localparam int SHORT_BYTES  = 2 * (HEAD_LAST + 1);
  localparam int LONG_BYTES   = 2 * (PROBE_IDX + 1);
  localparam logic [3:0] FMT_SHORT = 4'h0;
  localparam logic [3:0] FMT_LONG  = 4'h8;

  typedef enum logic [1:0] {RES_OK, RES_FMT, RES_BUS, RES_HALT} res_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HEAD, ST_VER, ST_PROBE, ST_BODY} st_e;
  typedef enum logic [1:0] {FR_SHORT, FR_LONG, FR_BAD} kind_e;
endpackage

// File: rtl/xret_fmt_decode.sv
module xret_fmt_decode
  import xret_pkg::*;
#(
  parameter logic [3:0] EXP_VER = 4'hA
) (
  input  logic [15:0] word_i,
  output kind_e       kind_o,
  output logic        ver_ok_o
);
  logic [3:0] code;
  assign code = word_i[15:12];

  always_comb begin
    unique case (code)
      FMT_SHORT: kind_o = FR_SHORT;
      FMT_LONG:  kind_o = FR_LONG;
      default:   kind_o = FR_BAD;
    endcase
  end

  assign ver_ok_o = (word_i[13:10] == EXP_VER);
endmodule

// File: rtl/xret_word_step.sv
module xret_word_step
  import xret_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [IDX_W-1:0]  next_body_o,
  output logic              body_last_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAD_W = ADDR_W - IDX_W - 1;

  // version word already consumed before the probe: skip it in the body walk
  assign next_body_o = (idx_i == IDX_W'(VER_IDX - 1)) ? IDX_W'(VER_IDX + 1)
                                                      : idx_i + IDX_W'(1);
  assign body_last_o = (idx_i == IDX_W'(BODY_LAST));
  assign addr_o      = base_i + {{PAD_W{1'b0}}, idx_i, 1'b0};
endmodule

// File: rtl/xret_frame_ctrl.sv
module xret_frame_ctrl
  import xret_pkg::*;
#(
  parameter int         ADDR_W  = 24,
  parameter logic [3:0] EXP_VER = 4'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [15:0]       rd_data_i,
  input  logic              rd_ack_i,
  input  logic              rd_berr_i,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              sp_we_o,
  output logic [ADDR_W-1:0] sp_new_o,
  output logic [15:0]       sr_o,
  output logic [31:0]       pc_o,
  output logic              rerun_o
);
  st_e               state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  kind_e             kind;
  logic              ver_ok;
  logic [IDX_W-1:0]  next_body;
  logic              body_last;

  xret_fmt_decode #(.EXP_VER(EXP_VER)) u_dec (
    .word_i  (rd_data_i),
    .kind_o  (kind),
    .ver_ok_o(ver_ok)
  );

  xret_word_step #(.ADDR_W(ADDR_W)) u_step (
    .base_i     (base_q),
    .idx_i      (idx_q),
    .next_body_o(next_body),
    .body_last_o(body_last),
    .addr_o     (rd_addr_o)
  );

  assign rd_req_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      base_q   <= '0;
      done_o   <= 1'b0;
      result_o <= RES_OK;
      sp_we_o  <= 1'b0;
      sp_new_o <= '0;
      sr_o     <= '0;
      pc_o     <= '0;
      rerun_o  <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      sp_we_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          base_q  <= sp_i;
          idx_q   <= '0;
          state_q <= ST_HEAD;
        end
      end else if (rd_berr_i) begin
        // after a good probe any fault is fatal
        done_o   <= 1'b1;
        result_o <= (state_q == ST_BODY) ? RES_HALT : RES_BUS;
        state_q  <= ST_IDLE;
      end else if (rd_ack_i) begin
        unique case (state_q)
          ST_HEAD: begin
            unique case (idx_q)
              IDX_W'(0): sr_o        <= rd_data_i;
              IDX_W'(1): pc_o[31:16] <= rd_data_i;
              IDX_W'(2): pc_o[15:0]  <= rd_data_i;
              default: ;
            endcase
            if (idx_q != IDX_W'(HEAD_LAST)) begin
              idx_q <= idx_q + IDX_W'(1);
            end else if (kind == FR_SHORT) begin
              done_o   <= 1'b1;
              result_o <= RES_OK;
              sp_we_o  <= 1'b1;
              sp_new_o <= base_q + ADDR_W'(SHORT_BYTES);
              rerun_o  <= 1'b0;
              state_q  <= ST_IDLE;
            end else if (kind == FR_LONG) begin
              idx_q   <= IDX_W'(VER_IDX);
              state_q <= ST_VER;
            end else begin
              done_o   <= 1'b1;
              result_o <= RES_FMT;
              state_q  <= ST_IDLE;
            end
          end
          ST_VER: begin
            if (ver_ok) begin
              idx_q   <= IDX_W'(PROBE_IDX);
              state_q <= ST_PROBE;
            end else begin
              done_o   <= 1'b1;
              result_o <= RES_FMT;
              state_q  <= ST_IDLE;
            end
          end
          ST_PROBE: begin
            idx_q   <= IDX_W'(SSW_IDX);
            state_q <= ST_BODY;
          end
          ST_BODY: begin
            if (idx_q == IDX_W'(SSW_IDX)) rerun_o <= ~rd_data_i[15];
            if (body_last) begin
              done_o   <= 1'b1;
              result_o <= RES_OK;
              sp_we_o  <= 1'b1;
              sp_new_o <= base_q + ADDR_W'(LONG_BYTES);
              state_q  <= ST_IDLE;
            end else begin
              idx_q <= next_body;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_sp_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> (done_o && result_o == RES_OK));

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && !rd_berr_i) |=> (rd_req_o && $stable(rd_addr_o)));

  p_base_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> $stable(base_q));

  p_halt_body_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_berr_i && state_q != ST_BODY) |=> (done_o && result_o == RES_BUS));

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_req_o && $past(rd_req_o)));
endmodule

// File: tb/xret_frame_ctrl_test.sv
module xret_frame_ctrl_test;
  localparam int         ADDR_W  = 24;
  localparam logic [3:0] EXP_VER = 4'hA;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] sp = '0;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic [15:0]       rd_data = '0;
  logic              rd_ack = 1'b0;
  logic              rd_berr = 1'b0;
  logic              done;
  logic [1:0]        result;
  logic              sp_we;
  logic [ADDR_W-1:0] sp_new;
  logic [15:0]       sr;
  logic [31:0]       pc;
  logic              rerun;

  always #4 clk = ~clk;

  xret_frame_ctrl #(.ADDR_W(ADDR_W), .EXP_VER(EXP_VER)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sp_i(sp),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .rd_ack_i(rd_ack), .rd_berr_i(rd_berr), .done_o(done),
    .result_o(result), .sp_we_o(sp_we), .sp_new_o(sp_new),
    .sr_o(sr), .pc_o(pc), .rerun_o(rerun)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] mem [29];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected word index of the n-th read
  function automatic int ord(int n);
    int b;
    if (n < 4) return n;
    if (n == 4) return 13;
    if (n == 5) return 28;
    b = n - 2;
    if (b >= 13) b = b + 1;
    return b;
  endfunction

  task automatic run_frame(input logic [ADDR_W-1:0] base, input logic [3:0] fmt,
                           input logic [3:0] ver, input int berr_at, input int max_wait,
                           input bit poke, input bit dual);
    int exp_res, exp_n, n_reads, bad_order, w, guard;
    bit tout;
    for (int i = 0; i < 29; i++) mem[i] = 16'($urandom);
    mem[3][15:12] = fmt;
    mem[13][13:10] = ver;
    exp_res = 0; exp_n = 0;
    for (int n = 0; n < 29; n++) begin
      exp_n = n + 1;
      if (ord(n) == berr_at) begin exp_res = (n >= 6) ? 3 : 2; break; end
      if (n == 3 && fmt == 4'h0) break;
      if (n == 3 && fmt != 4'h8) begin exp_res = 1; break; end
      if (n == 4 && ver != EXP_VER) begin exp_res = 1; break; end
    end
    @(negedge clk);
    sp = base; start = 1'b1;
    n_reads = 0; bad_order = 0; w = $urandom_range(max_wait); tout = 1;
    for (guard = 0; guard < 400; guard++) begin
      @(negedge clk);
      start = 1'b0; rd_ack = 1'b0; rd_berr = 1'b0;
      if (poke && n_reads == 8) begin start = 1'b1; sp = base + 24'h100; end
      if (done) begin tout = 0; break; end
      if (rd_req) begin
        if (w > 0) w--;
        else begin
          int idx;
          idx = int'((rd_addr - base) >> 1);
          if (idx != ord(n_reads)) bad_order++;
          if (idx >= 0 && idx < 29) rd_data = mem[idx];
          if (idx == berr_at) begin rd_berr = 1'b1; rd_ack = dual; end
          else rd_ack = 1'b1;
          n_reads++;
          w = $urandom_range(max_wait);
        end
      end
    end
    chk(!tout, "R9", "sequence finished", tout, 0);
    chk(result == 2'(exp_res), (exp_res == 3) ? "R6" : (exp_res == 2) ? "R5" :
        (exp_res == 1) ? "R3/R4" : "R2/R7", "result", result, exp_res);
    chk(n_reads == exp_n, "R6", "read count", n_reads, exp_n);
    chk(bad_order == 0, poke ? "R10" : "R1", "read order mismatches", bad_order, 0);
    chk(sp_we == (exp_res == 0), "R8", "sp commit strobe", sp_we, exp_res == 0);
    if (exp_res == 0) begin
      chk(sp_new == base + ((fmt == 4'h0) ? 24'd8 : 24'd58), "R7", "new sp",
          sp_new, base + ((fmt == 4'h0) ? 24'd8 : 24'd58));
      chk(rerun == ((fmt == 4'h8) ? ~mem[4][15] : 1'b0), "R7", "rerun",
          rerun, (fmt == 4'h8) ? ~mem[4][15] : 1'b0);
      chk(sr == mem[0] && pc == {mem[1], mem[2]}, "R1", "restored pc",
          pc, {mem[1], mem[2]});
    end
    @(negedge clk);
    chk(!done && !sp_we && !rd_req, "R8", "done is one pulse", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!done && !rd_req && !sp_we && result == 2'd0, "R8", "reset state", {done, rd_req, sp_we}, 0);
    rst_n = 1'b1;
    // directed corners
    run_frame(24'h001000, 4'h0, 4'h0, -1, 0, 0, 0);      // short
    run_frame(24'h002000, 4'h8, EXP_VER, -1, 1, 0, 0);   // long ok
    run_frame(24'h003000, 4'h8, EXP_VER, -1, 0, 1, 0);   // start while busy
    run_frame(24'h004000, 4'h3, EXP_VER, -1, 0, 0, 0);   // bad format
    run_frame(24'h005000, 4'h8, 4'h5, -1, 0, 0, 0);      // version mismatch
    run_frame(24'h006000, 4'h8, EXP_VER, 3, 0, 0, 0);    // berr on format word
    run_frame(24'h007000, 4'h8, EXP_VER, 28, 2, 0, 0);   // berr on probe
    run_frame(24'h008000, 4'h8, EXP_VER, 4, 0, 0, 1);    // first body word, ack+berr
    run_frame(24'h009000, 4'h8, EXP_VER, 27, 0, 0, 0);   // last body word
    run_frame(24'h00A000, 4'h8, EXP_VER, 13, 0, 0, 1);   // berr on version word
    // constrained random
    for (int k = 0; k < 60; k++) begin
      logic [3:0] f, v;
      int b;
      f = ($urandom_range(3) == 0) ? 4'h0 : ($urandom_range(4) == 0) ? 4'($urandom) : 4'h8;
      v = ($urandom_range(3) == 0) ? 4'($urandom) : EXP_VER;
      b = ($urandom_range(2) == 0) ? int'($urandom_range(28)) : -1;
      run_frame({4'h0, 19'($urandom), 1'b0}, f, v, b, 2, 0, $urandom_range(1) == 1);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule